// File: doc/BRIEF.md
# Seed-Reloaded LFSR Scan Vector Expander

This block turns short seeds delivered by a tester into long scan-chain test vectors. A seed arrives one bit per clock over a valid/ready handshake, most significant bit first. It becomes the starting state of a linear feedback shift register. The register then steps on its own and drives one bit per clock onto a single scan-data output for a fixed scan length. Each test vector gets its own fresh seed, so the register never free-runs from one vector into the next.

The controller has four named states. IDLE waits for the first seed bit. LOAD takes the remaining seed bits and spends one clock per bit. EXPAND drives the scan output with scan enable high and spends one clock per scan cell. DONE is a single-cycle completion pulse.

The transitions are as follows:
- IDLE goes to LOAD on the first accepted bit.
- LOAD goes to EXPAND on the last bit of a nonzero seed.
- LOAD goes back to IDLE, with the error flag raised, on the last bit of an all-zero seed.
- EXPAND goes to DONE after the final scan cell.
- DONE goes to IDLE.

A synchronous active-high reset returns the block to IDLE and clears the register.

Top module: `lfsr_reseed_decomp`

## Requirements
- R1: After reset the outputs are seed_ready=1, scan_en=0, done=0, seed_err=0 and scan_data=0.
- R2: A seed bit is taken on each clock edge where seed_valid and seed_ready are both high. Bits arrive MSB first, SEED_W bits per seed. Clocks with seed_valid low stall loading without losing bits.
- R3: On the clock after the last bit of a nonzero seed is taken, scan_en rises. It stays high for exactly SCAN_LEN consecutive cycles.
- R4: In each EXPAND cycle, scan_data is the register MSB. The first bit is the seed MSB. Between cycles the register steps as state <= {state[SEED_W-2:0], ^(state & TAPS)}, with TAPS = 32'h80200003 by default (x^32+x^22+x^2+x+1).
- R5: In the cycle after the last scan cell, done is high for exactly one cycle. The block is then back in IDLE with seed_ready=1.
- R6: seed_ready is low during EXPAND and DONE. seed_valid and seed_data have no effect on the scan stream in those states.
- R7: An all-zero seed raises seed_err on the clock after its last bit and returns the block to IDLE without asserting scan_en. seed_err clears when the first bit of the next seed is taken.
- R8: A reset asserted during expansion drops scan_en at once and returns the block to IDLE.
- R9: scan_data is 0 whenever scan_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_data | input | 1 | Serial seed bit, MSB first |
| seed_valid | input | 1 | Seed bit is valid |
| seed_ready | output | 1 | Block accepts a seed bit |
| scan_data | output | 1 | Expanded scan bit |
| scan_en | output | 1 | Scan shift enable, high during expansion |
| done | output | 1 | One-cycle completion pulse |
| seed_err | output | 1 | Last seed was all zero |

## Verification
The hardest case to reach is the boundary between the last seed bit and the first scan bit. The zero-seed check has to look at the incoming bit together with the partly loaded register, in the same cycle that decides between EXPAND and IDLE. Driving a seed with a stall in the middle lands that final bit at a shifted time. Sending an all-zero seed directly after a good expansion exercises the error branch and confirms that the error flag clears. Holding seed_valid high through a whole expansion shows that the scan stream is unaffected.

// File: rtl/lfsr_reseed_pkg.sv
package lfsr_reseed_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_EXPAND = 2'd2,
        ST_DONE   = 2'd3
    } rd_state_e;
endpackage

// File: rtl/rd_counter.sv
module rd_counter #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CW'(1);
        end
    end
endmodule

// File: rtl/rd_lfsr.sv
module rd_lfsr #(
    parameter int               W    = 32,
    parameter logic [W-1:0]     TAPS = 32'h80200003
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_in,
    input  logic         in_bit,
    input  logic         run,
    output logic [W-1:0] state,
    output logic         next_zero
);
    logic feedback;

    assign feedback  = ^(state & TAPS);
    assign next_zero = ({state[W-2:0], in_bit} == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else if (shift_in) begin
            state <= {state[W-2:0], in_bit};
        end else if (run) begin
            state <= {state[W-2:0], feedback};
        end
    end

    AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        run |-> (state != '0)) else $error("register zero while expanding"); // R7
endmodule

// File: rtl/rd_ctrl.sv
module rd_ctrl
    import lfsr_reseed_pkg::*;
#(
    parameter int SEED_W   = 32,
    parameter int SCAN_LEN = 256,
    parameter int CW       = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          seed_valid,
    input  logic          seed_zero,
    input  logic [CW-1:0] count,
    output logic          seed_ready,
    output logic          scan_en,
    output logic          done,
    output logic          seed_err,
    output logic          lfsr_load,
    output logic          lfsr_run,
    output logic          cnt_clr,
    output logic          cnt_inc
);
    localparam logic [CW-1:0] LAST_BIT  = CW'(SEED_W - 2);
    localparam logic [CW-1:0] LAST_CELL = CW'(SCAN_LEN - 1);

    rd_state_e state_q, state_d;
    logic      take;
    logic      err_set, err_clr;

    assign take = seed_valid && seed_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || err_clr) begin
            seed_err <= 1'b0;
        end else if (err_set) begin
            seed_err <= 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (take) state_d = ST_LOAD;
            ST_LOAD:   if (take && count == LAST_BIT)
                           state_d = seed_zero ? ST_IDLE : ST_EXPAND;
            ST_EXPAND: if (count == LAST_CELL) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        seed_ready = 1'b0;
        scan_en    = 1'b0;
        done       = 1'b0;
        lfsr_load  = 1'b0;
        lfsr_run   = 1'b0;
        cnt_clr    = 1'b0;
        cnt_inc    = 1'b0;
        err_set    = 1'b0;
        err_clr    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                seed_ready = 1'b1;
                cnt_clr    = 1'b1;
                lfsr_load  = take;
                err_clr    = take;
            end
            ST_LOAD: begin
                seed_ready = 1'b1;
                lfsr_load  = take;
                if (take && count == LAST_BIT) begin
                    cnt_clr = 1'b1;
                    err_set = seed_zero;
                end else begin
                    cnt_inc = take;
                end
            end
            ST_EXPAND: begin
                scan_en  = 1'b1;
                lfsr_run = 1'b1;
                if (count == LAST_CELL) cnt_clr = 1'b1;
                else                    cnt_inc = 1'b1;
            end
            ST_DONE: begin
                done    = 1'b1;
                cnt_clr = 1'b1;
            end
            default: ;
        endcase
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle"); // R5
    AST_DONE_AFTER_SCAN: assert property (@(posedge clk) disable iff (rst)
        ($fell(scan_en) && !$past(rst)) |-> done) else $error("scan ended without done"); // R5
    AST_NO_READY_IN_SCAN: assert property (@(posedge clk) disable iff (rst)
        (scan_en || done) |-> !seed_ready) else $error("ready during expansion"); // R6
    AST_ZERO_SEED_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(seed_err) |-> (!scan_en && seed_ready)) else $error("zero seed expanded"); // R7
    AST_SCAN_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        scan_en |-> (count <= LAST_CELL)) else $error("scan count overrun"); // R3
endmodule

// File: rtl/lfsr_reseed_decomp.sv
module lfsr_reseed_decomp #(
    parameter int                 SEED_W   = 32,
    parameter int                 SCAN_LEN = 256,
    parameter logic [SEED_W-1:0]  TAPS     = 32'h80200003
) (
    input  logic clk,
    input  logic rst,
    input  logic seed_data,
    input  logic seed_valid,
    output logic seed_ready,
    output logic scan_data,
    output logic scan_en,
    output logic done,
    output logic seed_err
);
    localparam int SPAN = (SEED_W > SCAN_LEN) ? SEED_W : SCAN_LEN;
    localparam int CW   = $clog2(SPAN) + 1;

    logic [SEED_W-1:0] lfsr_state;
    logic              seed_zero;
    logic              lfsr_load, lfsr_run, cnt_clr, cnt_inc;
    logic [CW-1:0]     count;

    rd_ctrl #(.SEED_W(SEED_W), .SCAN_LEN(SCAN_LEN), .CW(CW)) ctrl_i (
        .clk(clk), .rst(rst), .seed_valid(seed_valid), .seed_zero(seed_zero),
        .count(count), .seed_ready(seed_ready), .scan_en(scan_en), .done(done),
        .seed_err(seed_err), .lfsr_load(lfsr_load), .lfsr_run(lfsr_run),
        .cnt_clr(cnt_clr), .cnt_inc(cnt_inc)
    );

    rd_lfsr #(.W(SEED_W), .TAPS(TAPS)) lfsr_i (
        .clk(clk), .rst(rst), .shift_in(lfsr_load), .in_bit(seed_data),
        .run(lfsr_run), .state(lfsr_state), .next_zero(seed_zero)
    );

    rd_counter #(.CW(CW)) cnt_i (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc), .count(count)
    );

    assign scan_data = scan_en & lfsr_state[SEED_W-1];

    AST_QUIET_DATA: assert property (@(posedge clk) disable iff (rst)
        !scan_en |-> !scan_data) else $error("scan data outside expansion"); // R9
endmodule

// File: tb/lfsr_reseed_decomp_tb_top.sv
module lfsr_reseed_decomp_tb_top;
    localparam int          W    = 32;
    localparam int          LEN  = 256;
    localparam logic [31:0] TAPS = 32'h80200003;

    logic clk = 1'b0;
    logic rst, seed_data, seed_valid;
    logic seed_ready, scan_data, scan_en, done, seed_err;
    int   n_checks = 0, n_fail = 0;

    always #5 clk = ~clk;

    lfsr_reseed_decomp dut_i (
        .clk(clk), .rst(rst), .seed_data(seed_data), .seed_valid(seed_valid),
        .seed_ready(seed_ready), .scan_data(scan_data), .scan_en(scan_en),
        .done(done), .seed_err(seed_err)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; seed_valid = 1'b0; seed_data = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic send_seed(input logic [W-1:0] seed, input bit stall);
        for (int i = W - 1; i >= 0; i--) begin
            @(negedge clk);
            if (stall && i == 16) begin
                seed_valid = 1'b0; seed_data = ~seed[i];
                @(negedge clk);
            end
            seed_valid = 1'b1; seed_data = seed[i];
        end
        @(negedge clk);
        seed_valid = 1'b0;
    endtask

    task automatic expand_check(input logic [W-1:0] seed, input bit noise);
        logic [W-1:0] m = seed;
        if (noise) seed_valid = 1'b1;
        for (int k = 0; k < LEN; k++) begin
            if (noise) seed_data = k[0];
            check("R3 scan_en", scan_en, 1'b1);
            check("R4 scan_data", scan_data, m[W-1]);
            if (k == 0 || k == LEN - 1) check("R6 seed_ready", seed_ready, 1'b0);
            m = {m[W-2:0], ^(m & TAPS)};
            @(negedge clk);
        end
        check("R5 done", done, 1'b1);
        check("R3 scan_en low", scan_en, 1'b0);
        check("R6 ready low in done", seed_ready, 1'b0);
        seed_valid = 1'b0;
        @(negedge clk);
        check("R5 done single", done, 1'b0);
        check("R5 ready", seed_ready, 1'b1);
        check("R9 data quiet", scan_data, 1'b0);
    endtask

    task automatic t_reset();
        check("R1 ready", seed_ready, 1'b1);
        check("R1 scan_en", scan_en, 1'b0);
        check("R1 done", done, 1'b0);
        check("R1 err", seed_err, 1'b0);
        check("R1 data", scan_data, 1'b0);
    endtask

    task automatic t_vector(input logic [W-1:0] seed, input bit stall, input bit noise);
        send_seed(seed, stall);
        check("R2 loaded", scan_en, 1'b1);
        expand_check(seed, noise);
    endtask

    task automatic t_zero_seed();
        send_seed('0, 1'b0);
        check("R7 err", seed_err, 1'b1);
        check("R7 no scan", scan_en, 1'b0);
        check("R7 ready", seed_ready, 1'b1);
        @(negedge clk);
        check("R7 still idle", scan_en, 1'b0);
        seed_valid = 1'b1; seed_data = 1'b1;
        @(negedge clk);
        seed_valid = 1'b0;
        check("R7 err cleared", seed_err, 1'b0);
        do_reset();
    endtask

    task automatic t_abort();
        send_seed(32'hC0FFEE11, 1'b0);
        @(negedge clk); @(negedge clk);
        check("R8 running", scan_en, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R8 scan_en", scan_en, 1'b0);
        check("R8 ready", seed_ready, 1'b1);
        check("R8 done", done, 1'b0);
        check("R9 data", scan_data, 1'b0);
    endtask

    initial begin
        rst = 1'b1; seed_valid = 1'b0; seed_data = 1'b0;
        do_reset();
        t_reset();
        t_vector(32'h00000001, 1'b0, 1'b0);
        t_vector(32'hFFFFFFFF, 1'b1, 1'b0);
        t_vector(32'hA5A5F00D, 1'b0, 1'b1);
        t_zero_seed();
        t_vector(32'h80000000, 1'b1, 1'b0);
        t_abort();
        t_vector(32'h13579BDF, 1'b0, 1'b0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule